// File: doc/BRIEF.md
# Edge-Pulse Isolation Channel Codec

This block is one channel of a pulse-coupled digital isolator, written as synchronous logic. The transmit half watches a logic input. It turns each rising edge into a one-clock pulse on a set wire and each falling edge into a one-clock pulse on a reset wire. While the input holds still, the transmit half sends the current level again at a fixed idle interval, so the far side stays correct at DC.

The receive half keeps a bistable latch that the two wires drive. It also runs a loss-of-pulse watchdog. When pulses stop arriving, the watchdog declares the link down and the output falls back to a level chosen by a pin.

The two link wires come out of the top on both sides. An integrator can loop them back, or can route them through whatever carries the link. All intervals are set in nanoseconds and turned into clock cycles from the clock frequency parameter. At the default 100 MHz the refresh interval is 166 cycles (1660 ns) and the watchdog interval is 500 cycles (5000 ns).

Top module: `edge_iso_channel`

## Requirements
- R1: A rising edge on data_i gives exactly one cycle of link_set_o high, and a falling edge gives exactly one cycle of link_rst_o high. Each pulse is registered in the clock edge that first samples the new input level. The two link outputs are never high together.
- R2: A cycle with link_set_i high and link_rst_i low drives data_o to 1 from the next clock edge. A cycle with link_rst_i high and link_set_i low drives data_o to 0. data_o holds its value between pulses.
- R3: While data_i is unchanged, the transmitter sends a pulse of the current level every REFRESH_CYC cycles (166 at defaults): a set pulse when the input is 1 and a reset pulse when it is 0. With loopback this keeps link_ok_o high indefinitely.
- R4: Every transmitted pulse, whether from an edge or a refresh, restarts the idle timer. The first refresh therefore comes REFRESH_CYC cycles after the last edge pulse.
- R5: When no valid pulse arrives for WDOG_CYC cycles (500 at defaults), link_ok_o drops exactly WDOG_CYC clock edges after the edge that captured the last valid pulse, and data_o takes the default level.
- R6: While link_ok_o is low, data_o equals dflt_hi_i combinationally: 0 selects a default of 0 and 1 selects a default of 1.
- R7: After reset, link_ok_o is 0, data_o equals the default level, and neither link output pulses in the first cycle.
- R8: A cycle with link_set_i and link_rst_i both high is ignored. data_o keeps its value, and the watchdog is not restarted.
- R9: After the watchdog has expired, the first valid pulse sets data_o from that pulse's polarity, regardless of the default, and raises link_ok_o at the next clock edge.
- R10: Through loopback, input data toggling every 4 cycles (40 ns at 100 MHz, 25 Mbps NRZ) is reproduced on data_o with a fixed delay of 2 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| data_i | input | 1 | Logic level to be carried across the link |
| link_set_o | output | 1 | Transmit set pulse (input went or is high) |
| link_rst_o | output | 1 | Transmit reset pulse (input went or is low) |
| link_set_i | input | 1 | Received set pulse |
| link_rst_i | input | 1 | Received reset pulse |
| dflt_hi_i | input | 1 | Default output level used while the link is down |
| data_o | output | 1 | Recovered logic level |
| link_ok_o | output | 1 | High while valid pulses keep arriving |

## Verification
Each result is due a fixed number of clock edges after its stimulus:
- A transmit pulse appears one edge after data_i changes.
- The latched output appears one edge after a received pulse, so a loopback change is two edges from data_i to data_o.
- A refresh follows REFRESH_CYC edges after the previous pulse.
- The watchdog drops link_ok_o WDOG_CYC edges after the capturing edge.
- The default level follows dflt_hi_i with no clock at all while the link is down.

The bench drives inputs on falling edges and samples on falling edges. It counts those falling edges from the stimulus and checks each value on exactly the edge where it becomes due. Interval checks record the first falling edge at which the event is seen and compare that count against the expected cycle number.

// File: rtl/iso_pkg.sv
package iso_pkg;
  // Nanoseconds to clock cycles, truncating.
  function automatic int unsigned ns_to_cyc(input longint unsigned freq_hz,
                                            input longint unsigned ns);
    return int'((freq_hz * ns) / 64'd1_000_000_000);
  endfunction

  typedef struct packed {
    logic set;
    logic rst;
  } link_pulse_t;
endpackage

// File: rtl/iso_edge_tx.sv
module iso_edge_tx
  import iso_pkg::*;
#(
  parameter int unsigned REFRESH_CYC = 166
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        data_i,
  output link_pulse_t pulse_o
);
  localparam int unsigned CW = $clog2(REFRESH_CYC + 1);

  logic          lvl_q;
  logic [CW-1:0] idle_q;
  logic          rise, fall, ref_due, sent;

  always_comb begin
    rise    = data_i & ~lvl_q;
    fall    = ~data_i & lvl_q;
    ref_due = (idle_q == CW'(REFRESH_CYC - 1)) & ~rise & ~fall;
    sent    = rise | fall | ref_due;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q   <= 1'b0;
      idle_q  <= '0;
      pulse_o <= '0;
    end else begin
      lvl_q       <= data_i;
      pulse_o.set <= rise | (ref_due & data_i);
      pulse_o.rst <= fall | (ref_due & ~data_i);
      idle_q      <= sent ? '0 : idle_q + 1'b1;
    end
  end

  // R1
  no_dual_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pulse_o.set && pulse_o.rst));

  // R1
  set_on_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(data_i) |=> pulse_o.set);

  // R1
  rst_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(data_i) |=> pulse_o.rst);
endmodule

// File: rtl/iso_latch_rx.sv
module iso_latch_rx
  import iso_pkg::*;
#(
  parameter int unsigned WDOG_CYC = 500
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  link_pulse_t pulse_i,
  input  logic        dflt_hi_i,
  output logic        data_o,
  output logic        link_ok_o
);
  localparam int unsigned CW = $clog2(WDOG_CYC + 1);

  logic          q_r, ok_r;
  logic [CW-1:0] wd_q;
  logic          valid;

  assign valid = pulse_i.set ^ pulse_i.rst;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_r  <= 1'b0;
      ok_r <= 1'b0;
      wd_q <= '0;
    end else if (valid) begin
      q_r  <= pulse_i.set;
      ok_r <= 1'b1;
      wd_q <= '0;
    end else if (ok_r) begin
      if (wd_q == CW'(WDOG_CYC - 1)) ok_r <= 1'b0;
      else                           wd_q <= wd_q + 1'b1;
    end
  end

  assign data_o    = ok_r ? q_r : dflt_hi_i;
  assign link_ok_o = ok_r;

  // R2
  set_drives_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_i.set && !pulse_i.rst) |=> (link_ok_o && data_o));

  // R2
  rst_drives_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_i.rst && !pulse_i.set) |=> (link_ok_o && !data_o));

  // R8
  dual_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_i.set && pulse_i.rst) |=> $stable(q_r));

  // R5
  drop_needs_silence_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(link_ok_o) |-> !$past(pulse_i.set ^ pulse_i.rst));
endmodule

// File: rtl/edge_iso_channel.sv
module edge_iso_channel
  import iso_pkg::*;
#(
  parameter int unsigned CLK_FREQ_HZ = 100_000_000,
  parameter int unsigned REFRESH_NS  = 1660,
  parameter int unsigned WDOG_NS     = 5000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic data_i,
  output logic link_set_o,
  output logic link_rst_o,
  input  logic link_set_i,
  input  logic link_rst_i,
  input  logic dflt_hi_i,
  output logic data_o,
  output logic link_ok_o
);
  localparam int unsigned REFRESH_CYC = ns_to_cyc(CLK_FREQ_HZ, REFRESH_NS);
  localparam int unsigned WDOG_CYC    = ns_to_cyc(CLK_FREQ_HZ, WDOG_NS);

  link_pulse_t tx_p, rx_p;

  iso_edge_tx #(.REFRESH_CYC(REFRESH_CYC)) u_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .data_i  (data_i),
    .pulse_o (tx_p)
  );

  assign link_set_o = tx_p.set;
  assign link_rst_o = tx_p.rst;
  assign rx_p.set   = link_set_i;
  assign rx_p.rst   = link_rst_i;

  iso_latch_rx #(.WDOG_CYC(WDOG_CYC)) u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pulse_i   (rx_p),
    .dflt_hi_i (dflt_hi_i),
    .data_o    (data_o),
    .link_ok_o (link_ok_o)
  );
endmodule

// File: tb/sim_edge_iso_channel.sv
module sim_edge_iso_channel;
  localparam int CLK_PERIOD = 10;
  localparam int REF_CYC    = 166;
  localparam int WD_CYC     = 500;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic data_i = 1'b0;
  logic dflt = 1'b0;
  logic loop_en = 1'b0;
  logic inj_set = 1'b0;
  logic inj_rst = 1'b0;
  logic link_set_o, link_rst_o, data_o, link_ok_o;
  logic lset, lrst;
  int   n_chk = 0;
  int   n_err = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  assign lset = loop_en ? link_set_o : inj_set;
  assign lrst = loop_en ? link_rst_o : inj_rst;

  edge_iso_channel u0 (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .data_i     (data_i),
    .link_set_o (link_set_o),
    .link_rst_o (link_rst_o),
    .link_set_i (lset),
    .link_rst_i (lrst),
    .dflt_hi_i  (dflt),
    .data_o     (data_o),
    .link_ok_o  (link_ok_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic t_reset();
    // R7
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R7 link_ok after reset", int'(link_ok_o), 0);
    check("R7 data_o default", int'(data_o), 0);
    check("R7 no pulse", int'(link_set_o | link_rst_o), 0);
    // R6
    dflt = 1'b1;
    #1;
    check("R6 default high", int'(data_o), 1);
    dflt = 1'b0;
    #1;
    check("R6 default low", int'(data_o), 0);
  endtask

  task automatic t_edges();
    loop_en = 1'b1;
    @(negedge clk);
    data_i = 1'b1;
    @(negedge clk);
    check("R1 set pulse", int'(link_set_o), 1);
    check("R1 no reset pulse", int'(link_rst_o), 0);
    @(negedge clk);
    check("R1 set single cycle", int'(link_set_o), 0);
    check("R2 data_o high", int'(data_o), 1);
    check("R2 link_ok high", int'(link_ok_o), 1);
    repeat (5) @(negedge clk);
    check("R2 holds high", int'(data_o), 1);
    data_i = 1'b0;
    @(negedge clk);
    check("R1 reset pulse", int'(link_rst_o), 1);
    check("R1 no set pulse", int'(link_set_o), 0);
    @(negedge clk);
    check("R2 data_o low", int'(data_o), 0);
  endtask

  task automatic t_fast();
    // R10: toggle every 4 cycles, compare against value driven 2 steps earlier
    logic p1, p2;
    int   bad;
    p1  = data_i;
    p2  = data_i;
    bad = 0;
    for (int s = 0; s < 80; s++) begin
      @(negedge clk);
      if (data_o !== p2) bad++;
      p2 = p1;
      if (s % 4 == 0) data_i = ~data_i;
      p1 = data_i;
    end
    check("R10 40ns pulses follow", bad, 0);
  endtask

  task automatic t_refresh(input logic lvl);
    // R3 R4
    int n, first, prev, gap_bad, wrong;
    @(negedge clk);
    data_i = ~lvl;
    repeat (3) @(negedge clk);
    data_i  = lvl;
    first   = -1;
    prev    = -1;
    gap_bad = 0;
    wrong   = 0;
    n       = 0;
    for (int i = 1; i <= 1 + 4 * REF_CYC; i++) begin
      @(negedge clk);
      if (lvl ? link_rst_o : link_set_o) wrong++;
      if (lvl ? link_set_o : link_rst_o) begin
        if (first < 0) first = i;
        else begin
          if (prev == first) check("R4 first refresh after edge", i - prev, REF_CYC);
          else if (i - prev != REF_CYC) gap_bad++;
          n++;
        end
        prev = i;
      end
      if (i > 2 && data_o !== lvl) wrong++;
    end
    check("R1 edge pulse timing", first, 1);
    check("R3 refresh count", n, 4);
    check("R3 refresh spacing", gap_bad, 0);
    check("R3 level held, no wrong pulse", wrong, 0);
    check("R3 link stays up", int'(link_ok_o), 1);
  endtask

  task automatic t_watchdog();
    int hit;
    loop_en = 1'b0;
    dflt    = 1'b0;
    @(negedge clk);
    inj_set = 1'b1;
    @(negedge clk);
    inj_set = 1'b0;
    check("R2 injected set", int'(data_o), 1);
    hit = -1;
    for (int j = 1; j <= WD_CYC + 50; j++) begin
      @(negedge clk);
      if (!link_ok_o) begin
        hit = j;
        break;
      end
    end
    check("R5 watchdog interval", hit, WD_CYC);
    check("R5 default low after expiry", int'(data_o), 0);
    dflt = 1'b1;
    #1;
    check("R6 default follows pin", int'(data_o), 1);
    // R9
    @(negedge clk);
    inj_rst = 1'b1;
    @(negedge clk);
    inj_rst = 1'b0;
    check("R9 relink output", int'(data_o), 0);
    check("R9 relink ok", int'(link_ok_o), 1);
    dflt = 1'b0;
  endtask

  task automatic t_dual();
    int hit;
    @(negedge clk);
    inj_set = 1'b1;
    @(negedge clk);
    inj_set = 1'b0;
    hit = -1;
    for (int j = 1; j <= WD_CYC + 50; j++) begin
      @(negedge clk);
      if (j == 20) begin
        check("R8 dual pulse ignored", int'(data_o), 1);
        inj_set = 1'b0;
        inj_rst = 1'b0;
      end
      if (j == 19) begin
        inj_set = 1'b1;
        inj_rst = 1'b1;
      end
      if (!link_ok_o) begin
        hit = j;
        break;
      end
    end
    check("R8 dual does not restart watchdog", hit, WD_CYC);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_err++;
    $display("FAIL watchdog timeout actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_edges();
    t_fast();
    t_refresh(1'b1);
    t_refresh(1'b0);
    t_watchdog();
    t_dual();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule